// File: doc/BRIEF.md
# MSI-X Pending Bit Controller

This block keeps, for each of a few functions, a per-vector mask word, a per-vector pending word, a function enable bit and a function-wide mask bit. It serves one interrupt request at a time. A request carries a function number, a one-hot vector field and a two-bit mode. Depending on the mode, the block issues a message request for that vector, defers it by setting the vector's pending bit, reports the pending bit, or clears the pending bit and reports its earlier value. The clear mode lets software run an interrupt as permanently masked and poll it.

Deferred vectors are drained automatically on a valid/ready message output as soon as they become eligible. A vector is eligible when its own mask bit is clear, its function is enabled, and the function-wide mask is clear. Each request is answered by a one-cycle accept pulse or a one-cycle fail pulse. A status bit comes with the accept pulse. The mask words and the function control bits are written through a simple register write port.

Top module: `msix_pend_ctrl`

## Requirements
- R1: Mode 2'b00 on an eligible vector produces a message (function, vector index) on the message output, which has priority over drained vectors, with accept pulsed and status 0.
- R2: Mode 2'b00 on a vector that is masked, in a function-masked function or in a disabled function sets that vector's pending bit, issues no message, and pulses accept with status 1.
- R3: A pending vector that becomes eligible is offered on the message output, and its pending bit clears on the cycle the message is taken (msg_valid and msg_ready high).
- R4: Mode 2'b01 changes no state, issues no message, and pulses accept with status equal to the current pending bit of the selected vector.
- R5: Mode 2'b10 clears the selected pending bit, issues no message, and pulses accept with status equal to the pending bit's value before the clear.
- R6: A request is captured on a clock edge where req_strobe is sampled high after being sampled low. Accept or fail goes high on the following cycle, for exactly one cycle, and never both at once.
- R7: A vector field with zero or several bits set (bit i selects vector i), mode 2'b11, or a function number at or above the function count gives a one-cycle fail pulse with status 0 and leaves all pending bits unchanged.
- R8: When several deferred vectors are eligible, they leave one per taken message, lowest function first and then lowest vector. The output holds its offer while msg_ready is low.
- R9: A write with cfg_sel=0 loads the selected function's 32-bit vector mask word (bit i masks vector i). A write with cfg_sel=1 sets the enable from cfg_wdata[0] and the function mask from cfg_wdata[1]. fn_enable and fn_mask show these bits. Writes to a function number that is out of range have no effect.
- R10: A mode 2'b00 request that must send while an earlier immediate message has not been taken waits without answering. Strobe edges seen during that wait are ignored, and the waiting request is answered exactly once after the slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Request strobe, acted on at its rising edge |
| req_func | input | 8 | Function number of the request |
| req_vec | input | 32 | One-hot vector select |
| req_mode | input | 2 | 00 send, 01 query, 10 clear |
| req_ack | output | 1 | One-cycle accept pulse |
| req_fail | output | 1 | One-cycle fail pulse |
| pend_status | output | 1 | Status bit, valid with req_ack |
| msg_valid | output | 1 | A message request is offered |
| msg_ready | input | 1 | The message consumer takes the offer |
| msg_func | output | 8 | Function number of the offered message |
| msg_vec | output | 5 | Vector index of the offered message |
| cfg_we | input | 1 | Register write strobe |
| cfg_func | input | 8 | Function addressed by the write |
| cfg_sel | input | 1 | 0 vector mask word, 1 function control bits |
| cfg_wdata | input | 32 | Write data |
| fn_enable | output | 4 | Per-function enable bits |
| fn_mask | output | 4 | Per-function function-wide mask bits |

## Verification
The hardest situation to reach is a send request that has to wait. This needs an immediate message still unclaimed while a drained vector is also waiting behind it, and a further strobe edge arriving during the wait. The stimulus holds msg_ready low and unmasks a pending vector so that a drain offer is standing. It then issues one immediate send to fill the slot, a second send that must stall, and a stray query edge. Finally it releases msg_ready and checks that the messages come out in the order immediate, drained, stalled, with exactly two accepts. Drain ordering is reached the same way: several vectors are deferred behind masks and the masks are lifted while the consumer is not ready.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int unsigned NUM_FUNC  = 4;
    localparam int unsigned NUM_VEC   = 32;
    localparam int unsigned FUNC_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned VEC_IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam int unsigned FIDX_W    = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

    typedef enum logic [1:0] {
        MODE_SEND  = 2'b00,
        MODE_QUERY = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_RSVD  = 2'b11
    } req_mode_e;

    typedef enum logic {
        CFG_VEC_MASK  = 1'b0,
        CFG_FUNC_CTRL = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic [FUNC_W-1:0]  func;
        logic [NUM_VEC-1:0] vec;
        req_mode_e          mode;
    } req_t;

    typedef struct packed {
        logic [FUNC_W-1:0]    func;
        logic [VEC_IDX_W-1:0] vec;
    } msg_t;

    typedef logic [NUM_FUNC-1:0][NUM_VEC-1:0] vec_grid_t;

    function automatic logic is_onehot(logic [NUM_VEC-1:0] v);
        return (v != '0) && ((v & (v - NUM_VEC'(1))) == '0);
    endfunction

    function automatic logic [VEC_IDX_W-1:0] onehot_index(logic [NUM_VEC-1:0] v);
        logic [VEC_IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (v[i]) idx = VEC_IDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/msix_req_capture.sv
module msix_req_capture
    import msix_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  req_t req_i,
    input  logic done_i,
    output logic cap_v_o,
    output req_t cap_o
);

    logic strobe_q;
    logic rise;

    assign rise = strobe_i && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            cap_v_o  <= 1'b0;
            cap_o    <= '0;
        end else begin
            strobe_q <= strobe_i;
            if (cap_v_o) begin
                if (done_i) cap_v_o <= 1'b0;
            end else if (rise) begin
                cap_v_o <= 1'b1;
                cap_o   <= req_i;
            end
        end
    end

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_v_o && !done_i) |=> (cap_v_o && $stable(cap_o)));

endmodule

// File: rtl/msix_vec_store.sv
module msix_vec_store
    import msix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [FUNC_W-1:0]    cfg_func,
    input  cfg_sel_e             cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 set_en,
    input  logic                 clr_en,
    input  logic [FIDX_W-1:0]    upd_func,
    input  logic [VEC_IDX_W-1:0] upd_vec,
    input  logic                 drain_en,
    input  logic [FIDX_W-1:0]    drain_func,
    input  logic [VEC_IDX_W-1:0] drain_vec,
    output vec_grid_t            vmask_o,
    output vec_grid_t            pend_o,
    output logic [NUM_FUNC-1:0]  fen_o,
    output logic [NUM_FUNC-1:0]  fmask_o
);

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        logic               hit;
        logic [NUM_VEC-1:0] pend_nxt;

        assign hit = cfg_we && (cfg_func == FUNC_W'(f));

        always_comb begin
            pend_nxt = pend_o[f];
            if (drain_en && drain_func == FIDX_W'(f)) pend_nxt[drain_vec] = 1'b0;
            if (set_en && upd_func == FIDX_W'(f))     pend_nxt[upd_vec]   = 1'b1;
            if (clr_en && upd_func == FIDX_W'(f))     pend_nxt[upd_vec]   = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[f]  <= '0;
                vmask_o[f] <= '0;
                fen_o[f]   <= 1'b0;
                fmask_o[f] <= 1'b0;
            end else begin
                pend_o[f] <= pend_nxt;
                if (hit && cfg_sel == CFG_VEC_MASK) vmask_o[f] <= cfg_wdata[NUM_VEC-1:0];
                if (hit && cfg_sel == CFG_FUNC_CTRL) begin
                    fen_o[f]   <= cfg_wdata[0];
                    fmask_o[f] <= cfg_wdata[1];
                end
            end
        end
    end

    // R4 R5
    set_clr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en));

    // R3
    drain_pending_chk: assert property (@(posedge clk) disable iff (rst)
        drain_en |-> pend_o[drain_func][drain_vec]);

endmodule

// File: rtl/msix_drain_arb.sv
module msix_drain_arb
    import msix_pkg::*;
(
    input  vec_grid_t            pend_i,
    input  vec_grid_t            vmask_i,
    input  logic [NUM_FUNC-1:0]  fen_i,
    input  logic [NUM_FUNC-1:0]  fmask_i,
    output logic                 any_o,
    output logic [FIDX_W-1:0]    func_o,
    output logic [VEC_IDX_W-1:0] vec_o
);

    vec_grid_t elig;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_elig
        assign elig[f] = pend_i[f] & ~vmask_i[f] & {NUM_VEC{fen_i[f] & ~fmask_i[f]}};
    end

    always_comb begin
        any_o  = 1'b0;
        func_o = '0;
        vec_o  = '0;
        for (int f = NUM_FUNC - 1; f >= 0; f--) begin
            for (int v = NUM_VEC - 1; v >= 0; v--) begin
                if (elig[f][v]) begin
                    any_o  = 1'b1;
                    func_o = FIDX_W'(f);
                    vec_o  = VEC_IDX_W'(v);
                end
            end
        end
    end

endmodule

// File: rtl/msix_pend_ctrl.sv
module msix_pend_ctrl
    import msix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_strobe,
    input  logic [FUNC_W-1:0]    req_func,
    input  logic [NUM_VEC-1:0]   req_vec,
    input  logic [1:0]           req_mode,
    output logic                 req_ack,
    output logic                 req_fail,
    output logic                 pend_status,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [FUNC_W-1:0]    msg_func,
    output logic [VEC_IDX_W-1:0] msg_vec,
    input  logic                 cfg_we,
    input  logic [FUNC_W-1:0]    cfg_func,
    input  logic                 cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [NUM_FUNC-1:0]  fn_enable,
    output logic [NUM_FUNC-1:0]  fn_mask
);

    req_t                 req_in;
    req_t                 cap;
    logic                 cap_v;
    logic                 fire;
    vec_grid_t            vmask, pend;
    logic                 drain_any;
    logic [FIDX_W-1:0]    drain_f;
    logic [VEC_IDX_W-1:0] drain_v;

    logic                 req_ok, send_now, eff_mask, pend_bit;
    logic                 set_en, clr_en, drain_en;
    logic [FIDX_W-1:0]    fidx;
    logic [VEC_IDX_W-1:0] vidx;

    logic direct_v;
    msg_t direct_msg;

    always_comb begin
        req_in.func = req_func;
        req_in.vec  = req_vec;
        req_in.mode = req_mode_e'(req_mode);
    end

    msix_req_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (req_strobe),
        .req_i    (req_in),
        .done_i   (fire),
        .cap_v_o  (cap_v),
        .cap_o    (cap)
    );

    // decode of the captured request
    always_comb begin
        fidx     = FIDX_W'(cap.func);
        vidx     = onehot_index(cap.vec);
        req_ok   = is_onehot(cap.vec) && (cap.mode != MODE_RSVD)
                   && (cap.func < FUNC_W'(NUM_FUNC));
        eff_mask = vmask[fidx][vidx] | fn_mask[fidx] | ~fn_enable[fidx];
        pend_bit = pend[fidx][vidx];
        send_now = req_ok && (cap.mode == MODE_SEND) && !eff_mask;
        fire     = cap_v && !(send_now && direct_v);
        set_en   = fire && req_ok && (cap.mode == MODE_SEND) && eff_mask;
        clr_en   = fire && req_ok && (cap.mode == MODE_CLEAR);
        drain_en = msg_ready && !direct_v && drain_any;
    end

    msix_vec_store u_store (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_func   (cfg_func),
        .cfg_sel    (cfg_sel_e'(cfg_sel)),
        .cfg_wdata  (cfg_wdata),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .upd_func   (fidx),
        .upd_vec    (vidx),
        .drain_en   (drain_en),
        .drain_func (drain_f),
        .drain_vec  (drain_v),
        .vmask_o    (vmask),
        .pend_o     (pend),
        .fen_o      (fn_enable),
        .fmask_o    (fn_mask)
    );

    msix_drain_arb u_arb (
        .pend_i  (pend),
        .vmask_i (vmask),
        .fen_i   (fn_enable),
        .fmask_i (fn_mask),
        .any_o   (drain_any),
        .func_o  (drain_f),
        .vec_o   (drain_v)
    );

    // response and immediate-message slot
    always_ff @(posedge clk) begin
        if (rst) begin
            req_ack     <= 1'b0;
            req_fail    <= 1'b0;
            pend_status <= 1'b0;
            direct_v    <= 1'b0;
            direct_msg  <= '0;
        end else begin
            req_ack  <= fire && req_ok;
            req_fail <= fire && !req_ok;
            if (fire && req_ok) begin
                pend_status <= (cap.mode == MODE_SEND) ? eff_mask : pend_bit;
            end else begin
                pend_status <= 1'b0;
            end
            if (fire && send_now) begin
                direct_v        <= 1'b1;
                direct_msg.func <= FUNC_W'(fidx);
                direct_msg.vec  <= vidx;
            end else if (direct_v && msg_ready) begin
                direct_v <= 1'b0;
            end
        end
    end

    assign msg_valid = direct_v || drain_any;
    assign msg_func  = direct_v ? direct_msg.func : FUNC_W'(drain_f);
    assign msg_vec   = direct_v ? direct_msg.vec  : drain_v;

    // R6
    ack_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ack && req_fail));

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ack || req_fail) |=> !(req_ack || req_fail));

    // R1
    direct_acked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(direct_v) |-> (req_ack && !pend_status));

    // R7
    fail_status_chk: assert property (@(posedge clk) disable iff (rst)
        req_fail |-> !pend_status);

endmodule

// File: tb/msix_pend_ctrl_tb.sv
module msix_pend_ctrl_tb;
    import msix_pkg::*;

    localparam int NF = NUM_FUNC;
    localparam int NV = NUM_VEC;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_strobe = 1'b0;
    logic [7:0]  req_func = '0;
    logic [31:0] req_vec = '0;
    logic [1:0]  req_mode = '0;
    logic        req_ack, req_fail, pend_status, msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_func;
    logic [4:0]  msg_vec;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_func = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  fn_enable, fn_mask;

    msix_pend_ctrl u_dut (
        .clk(clk), .rst(rst), .req_strobe(req_strobe), .req_func(req_func),
        .req_vec(req_vec), .req_mode(req_mode), .req_ack(req_ack),
        .req_fail(req_fail), .pend_status(pend_status), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_func(msg_func), .msg_vec(msg_vec),
        .cfg_we(cfg_we), .cfg_func(cfg_func), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fn_enable(fn_enable), .fn_mask(fn_mask)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ack_cnt = 0;
    bit finished = 0;
    int logf[$];
    int logv[$];

    // reference model state
    bit m_vm [NF][NV];
    bit m_pd [NF][NV];
    bit m_en [NF];
    bit m_fm [NF];
    bit m_dv, m_cv, m_prev, m_ack, m_fail, m_st;
    int m_df, m_dvi, m_cf;
    logic [31:0] m_cvec;
    logic [1:0]  m_cm;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_pick();
        for (int f = 0; f < NF; f++)
            for (int v = 0; v < NV; v++)
                if (m_pd[f][v] && !m_vm[f][v] && m_en[f] && !m_fm[f]) return f * NV + v;
        return -1;
    endfunction

    always @(posedge clk) begin : model
        int p, vi, ones, f;
        bit ok, msk, take_d, take_p, stall, fire, old_cv;
        if (rst) begin
            for (int a = 0; a < NF; a++) begin
                m_en[a] = 0; m_fm[a] = 0;
                for (int b = 0; b < NV; b++) begin m_vm[a][b] = 0; m_pd[a][b] = 0; end
            end
            m_dv = 0; m_cv = 0; m_prev = 0; m_ack = 0; m_fail = 0; m_st = 0;
            m_df = 0; m_dvi = 0; m_cf = 0; m_cvec = '0; m_cm = '0;
        end else begin
            p = m_pick();
            take_d = m_dv && msg_ready;
            take_p = !m_dv && (p >= 0) && msg_ready;
            ones = 0; vi = 0;
            for (int b = 0; b < NV; b++) if (m_cvec[b]) begin ones++; vi = b; end
            ok = (ones == 1) && (m_cm != 2'b11) && (m_cf < NF);
            f = ok ? m_cf : 0;
            msk = ok ? (m_vm[f][vi] || m_fm[f] || !m_en[f]) : 0;
            stall = m_cv && ok && (m_cm == 2'b00) && !msk && m_dv;
            fire = m_cv && !stall;
            old_cv = m_cv;
            m_ack = fire && ok;
            m_fail = fire && !ok;
            m_st = (fire && ok) ? ((m_cm == 2'b00) ? msk : m_pd[f][vi]) : 0;
            if (take_p) m_pd[p / NV][p % NV] = 0;
            if (fire && ok && m_cm == 2'b00 && msk) m_pd[f][vi] = 1;
            if (fire && ok && m_cm == 2'b10) m_pd[f][vi] = 0;
            if (fire && ok && m_cm == 2'b00 && !msk) begin
                m_dv = 1; m_df = f; m_dvi = vi;
            end else if (take_d) m_dv = 0;
            if (cfg_we && cfg_func < NF) begin
                if (!cfg_sel) for (int b = 0; b < NV; b++) m_vm[cfg_func][b] = cfg_wdata[b];
                else begin m_en[cfg_func] = cfg_wdata[0]; m_fm[cfg_func] = cfg_wdata[1]; end
            end
            if (fire) m_cv = 0;
            if (req_strobe && !m_prev && !old_cv) begin
                m_cv = 1; m_cf = req_func; m_cvec = req_vec; m_cm = req_mode;
            end
            m_prev = req_strobe;
        end
    end

    // message log, taken handshakes
    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            logf.push_back(int'(msg_func));
            logv.push_back(int'(msg_vec));
        end
    end

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin : compare
        int p, ef, ev;
        bit emv;
        logic [3:0] een, efm;
        if (!rst && !finished) begin
            p = m_pick();
            emv = m_dv || (p >= 0);
            ef = m_dv ? m_df : (p >= 0 ? p / NV : 0);
            ev = m_dv ? m_dvi : (p >= 0 ? p % NV : 0);
            for (int a = 0; a < NF; a++) begin een[a] = m_en[a]; efm[a] = m_fm[a]; end
            chk("R6", "ack", req_ack, m_ack);
            chk("R7", "fail", req_fail, m_fail);
            chk("R4", "status", pend_status, m_st);
            chk("R8", "msg_valid", msg_valid, emv);
            if (emv) begin
                chk("R8", "msg_func", msg_func, ef);
                chk("R8", "msg_vec", msg_vec, ev);
            end
            chk("R9", "fn_enable", fn_enable, een);
            chk("R9", "fn_mask", fn_mask, efm);
            if (req_ack) ack_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cfg_wr(input int f, input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_func = 8'(f); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_req(input int f, input logic [31:0] v, input logic [1:0] m);
        @(negedge clk);
        req_func = 8'(f); req_vec = v; req_mode = m; req_strobe = 1;
        @(negedge clk);
        req_strobe = 0;
    endtask

    task automatic do_req(input int f, input logic [31:0] v, input logic [1:0] m,
                          output logic a, output logic fl, output logic st);
        a = 0; fl = 0; st = 0;
        pulse_req(f, v, m);
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #1;
            if (req_ack || req_fail) begin
                a = req_ack; fl = req_fail; st = pend_status;
                break;
            end
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic a, fl, st;
        int snap;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R6", "reset ack", req_ack, 0);
        chk("R3", "reset msg_valid", msg_valid, 0);
        chk("R9", "reset enable", fn_enable, 4'h0);

        // R9 control writes
        for (int f = 0; f < NF; f++) cfg_wr(f, 1, 32'h1);
        cfg_wr(2, 1, 32'h3);
        cfg_wr(9, 1, 32'h3);
        wait_cyc(1);
        chk("R9", "enable after writes", fn_enable, 4'hF);
        chk("R9", "fn mask f2 only", fn_mask, 4'b0100);

        // R1 immediate send
        logf.delete(); logv.delete();
        do_req(0, 32'h8, 2'b00, a, fl, st);
        chk("R1", "send ack", a, 1);
        chk("R1", "send status", st, 0);
        wait_cyc(3);
        chk("R1", "send msg count", logf.size(), 1);
        if (logf.size() == 1) begin
            chk("R1", "send func", logf[0], 0);
            chk("R1", "send vec", logv[0], 3);
        end

        // R2 deferred by vector mask, R4 query
        logf.delete(); logv.delete();
        cfg_wr(1, 0, 32'h20);
        do_req(1, 32'h20, 2'b00, a, fl, st);
        chk("R2", "defer ack", a, 1);
        chk("R2", "defer status", st, 1);
        do_req(1, 32'h20, 2'b01, a, fl, st);
        chk("R4", "query pending", st, 1);
        do_req(1, 32'h40, 2'b01, a, fl, st);
        chk("R4", "query idle vector", st, 0);
        wait_cyc(3);
        chk("R2", "no msg while masked", logf.size(), 0);

        // R3 drain on unmask
        cfg_wr(1, 0, 32'h0);
        wait_cyc(3);
        chk("R3", "drain count", logf.size(), 1);
        if (logf.size() == 1) chk("R3", "drain vec", logv[0], 5);
        do_req(1, 32'h20, 2'b01, a, fl, st);
        chk("R3", "pending cleared", st, 0);

        // R5 clear reports prior value
        logf.delete(); logv.delete();
        cfg_wr(0, 0, 32'h80);
        do_req(0, 32'h80, 2'b00, a, fl, st);
        chk("R2", "defer f0v7", st, 1);
        do_req(0, 32'h80, 2'b10, a, fl, st);
        chk("R5", "clear prior set", st, 1);
        do_req(0, 32'h80, 2'b10, a, fl, st);
        chk("R5", "clear prior clear", st, 0);
        cfg_wr(0, 0, 32'h0);
        wait_cyc(3);
        chk("R5", "no msg after clear", logf.size(), 0);

        // R7 error cases
        cfg_wr(1, 0, 32'hFFFF_FFFF);
        do_req(1, 32'h0, 2'b00, a, fl, st);
        chk("R7", "zero vec fail", fl, 1);
        do_req(1, 32'h3, 2'b00, a, fl, st);
        chk("R7", "two-hot fail", fl, 1);
        chk("R7", "two-hot no ack", a, 0);
        do_req(1, 32'h1, 2'b11, a, fl, st);
        chk("R7", "mode 11 fail", fl, 1);
        do_req(9, 32'h1, 2'b00, a, fl, st);
        chk("R7", "bad func fail", fl, 1);
        do_req(1, 32'h1, 2'b01, a, fl, st);
        chk("R7", "v0 untouched", st, 0);
        do_req(1, 32'h2, 2'b01, a, fl, st);
        chk("R7", "v1 untouched", st, 0);

        // R8 drain order
        logf.delete(); logv.delete();
        msg_ready = 0;
        cfg_wr(3, 0, 32'hFFFF_FFFF);
        cfg_wr(2, 1, 32'h3);
        do_req(3, 32'h4, 2'b00, a, fl, st);
        do_req(3, 32'h2, 2'b00, a, fl, st);
        do_req(1, 32'h200, 2'b00, a, fl, st);
        do_req(2, 32'h1, 2'b00, a, fl, st);
        chk("R2", "defer by function mask", st, 1);
        cfg_wr(3, 0, 32'h0);
        cfg_wr(1, 0, 32'h0);
        cfg_wr(2, 1, 32'h1);
        wait_cyc(2);
        chk("R8", "offer held f1", msg_func, 1);
        chk("R8", "offer held v9", msg_vec, 9);
        msg_ready = 1;
        wait_cyc(8);
        chk("R8", "drain count", logf.size(), 4);
        if (logf.size() == 4) begin
            chk("R8", "order 0", logf[0] * 100 + logv[0], 109);
            chk("R8", "order 1", logf[1] * 100 + logv[1], 200);
            chk("R8", "order 2", logf[2] * 100 + logv[2], 301);
            chk("R8", "order 3", logf[3] * 100 + logv[3], 302);
        end

        // R10 / R11 stall with ignored edge
        logf.delete(); logv.delete();
        cfg_wr(0, 0, 32'h10);
        do_req(0, 32'h10, 2'b00, a, fl, st);
        msg_ready = 0;
        cfg_wr(0, 0, 32'h0);
        snap = ack_cnt;
        do_req(1, 32'h1, 2'b00, a, fl, st);
        chk("R1", "direct ack", a, 1);
        chk("R1", "direct priority func", msg_func, 1);
        chk("R1", "direct priority vec", msg_vec, 0);
        pulse_req(2, 32'h2, 2'b00);
        wait_cyc(3);
        pulse_req(3, 32'h40, 2'b01);
        wait_cyc(3);
        msg_ready = 1;
        wait_cyc(10);
        chk("R10", "accept count", ack_cnt - snap, 2);
        chk("R10", "msg count", logf.size(), 3);
        if (logf.size() == 3) begin
            chk("R10", "order 0", logf[0] * 100 + logv[0], 100);
            chk("R10", "order 1", logf[1] * 100 + logv[1], 4);
            chk("R10", "order 2", logf[2] * 100 + logv[2], 201);
        end

        wait_cyc(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule